// File: doc/BRIEF.md
# Machine-Check Interrupt Controller

This block decides when a processor takes a machine-check interrupt. It watches two separate error sources: one reported with instruction-cache line fills and one reported by the data side of the bus. Each cache line carries an error tag. A faulty fill raises nothing when it happens. The exception is taken only when an instruction from that line reaches the execute boundary, and that hit always invalidates the line.

Data-side errors are latched while the machine-check enable is set. They are taken at the next instruction boundary. When the interrupt is taken, the block saves the boundary address and the current machine state into a critical save pair. It then issues a load of the machine state with every maskable enable cleared and presents the vector offset. A critical return reloads the saved machine state.

A sticky status bit records every instruction-side machine check, whether or not the interrupt is enabled. Software clears it by writing 0.

Top module: `mchk_ctrl`

## Requirements
- R1: After reset, `mc_irq`, `msr_ld`, `inv_vld` and `imc_sticky` are 0, and no cache line carries an error tag.
- R2: `mc_vec` always reads 0x0200.
- R3: A fill with `fill_err`=1 tags its line and raises no interrupt. A later `exec_vld` on that line, with the enable bit (`msr_in[ME_POS]`, default bit 12) at 1, raises `mc_irq` one cycle later with `mc_cause`=0.
- R4: When an interrupt is taken, `save_pc` receives `exec_pc` and `save_msr` receives `msr_in`. In the same cycle as `mc_irq`, `msr_ld`=1 and `msr_nxt`=`msr_in` with every bit of `MASK` cleared, which includes the enable bit.
- R5: `mc_irq` lasts exactly one cycle. No interrupt is taken in a cycle where `msr_ld` is 1.
- R6: Every execution from a tagged line produces `inv_vld`=1 one cycle later, with `inv_idx` equal to that line. The tag is then cleared, and this happens whatever the enable bit is.
- R7: A fill with `fill_err`=0 clears the line's tag. A fill in the same cycle as an invalidation of the same line sets the tag to the fill's `fill_err`.
- R8: `imc_sticky` becomes 1 one cycle after any tagged-line execution, with the enable bit at 0 or 1. A write with `stat_wd`=0 clears it. A write with `stat_wd`=1 has no effect. A hardware set wins over a clear in the same cycle.
- R9: With the enable bit at 0, no interrupt is raised for either cause.
- R10: A data error (`dbus_err`) seen while the enable bit is 1 is taken at a later `exec_vld` with `mc_cause`=1. An error in the same cycle as a boundary is taken at the following boundary.
- R11: A data error is not persistent. It is dropped if it arrives with the enable bit at 0, if the enable bit drops while it is pending, or when any interrupt is taken.
- R12: When a tagged-line execution and a pending data error meet at the same boundary, the instruction cause (0) is taken and the data error is dropped.
- R13: A `rfci` pulse gives `msr_ld`=1 one cycle later, with `msr_nxt` equal to `save_msr`. `save_pc` holds the return address.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| fill_vld | input | 1 | Instruction-cache line fill completes |
| fill_idx | input | IDX_W | Line being filled |
| fill_err | input | 1 | Fill carried an instruction bus error |
| exec_vld | input | 1 | Instruction boundary: an instruction is about to execute |
| exec_idx | input | IDX_W | Cache line of that instruction |
| exec_pc | input | PC_W | Address of that instruction |
| dbus_err | input | 1 | Data-side bus error pulse |
| msr_in | input | MSR_W | Current machine state |
| rfci | input | 1 | Critical return executes |
| stat_wr | input | 1 | Software write to the sticky status bit |
| stat_wd | input | 1 | Value written |
| mc_irq | output | 1 | Interrupt taken, one-cycle pulse |
| mc_cause | output | 1 | 0 instruction error, 1 data error |
| mc_vec | output | VEC_W | Vector offset |
| inv_vld | output | 1 | Invalidate a cache line |
| inv_idx | output | IDX_W | Line to invalidate |
| save_pc | output | PC_W | Saved return address |
| save_msr | output | MSR_W | Saved machine state |
| msr_ld | output | 1 | Load `msr_nxt` into the machine state |
| msr_nxt | output | MSR_W | New machine state |
| imc_sticky | output | 1 | Sticky instruction machine-check status |

## Verification
The bench builds the block with `LINES`=8 and keeps the default 32-bit widths, enable position and mask. With only eight lines, random fills and executions collide on the same line often. That covers refill-over-tag, fill racing invalidation, and repeated hits on one line in a few thousand cycles. Random toggling of the enable bit, mixed with data errors, reaches the discard paths for non-persistent errors and the case where both causes are pending at the same boundary.

// File: rtl/mchk_pkg.sv
package mchk_pkg;
  typedef enum logic {CAUSE_INSTR = 1'b0, CAUSE_DATA = 1'b1} mc_cause_e;

  // instruction side wins whenever it is present at the boundary
  function automatic mc_cause_e pick_cause(input logic instr_hit);
    return instr_hit ? CAUSE_INSTR : CAUSE_DATA;
  endfunction
endpackage

// File: rtl/mchk_tags.sv
module mchk_tags #(
  parameter int LINES = 16,
  parameter int IDX_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             fill_vld,
  input  logic [IDX_W-1:0] fill_idx,
  input  logic             fill_err,
  input  logic             clr_en,
  input  logic [IDX_W-1:0] clr_idx,
  input  logic [IDX_W-1:0] rd_idx,
  output logic             rd_hit
);
  logic [LINES-1:0] tag_q;

  for (genvar g = 0; g < LINES; g++) begin : g_line
    always_ff @(posedge clk) begin
      if (!rst_n)
        tag_q[g] <= 1'b0;
      else if (fill_vld && fill_idx == IDX_W'(g))
        tag_q[g] <= fill_err;          // fill has the last word
      else if (clr_en && clr_idx == IDX_W'(g))
        tag_q[g] <= 1'b0;
    end
  end

  assign rd_hit = tag_q[rd_idx];
endmodule

// File: rtl/mchk_arb.sv
module mchk_arb import mchk_pkg::*; (
  input  logic      clk,
  input  logic      rst_n,
  input  logic      boundary,
  input  logic      me,
  input  logic      busy,
  input  logic      ievt,
  input  logic      dbus_err,
  output logic      take,
  output mc_cause_e take_cause,
  output logic      dpend_q
);
  logic ok, take_i, take_d;

  always_comb begin
    ok         = boundary && me && !busy;
    take_i     = ok && ievt;
    take_d     = ok && !ievt && dpend_q;
    take       = take_i || take_d;
    take_cause = pick_cause(take_i);
  end

  always_ff @(posedge clk) begin
    if (!rst_n)
      dpend_q <= 1'b0;
    else if (take || !me)
      dpend_q <= 1'b0;                 // not persistent
    else
      dpend_q <= dpend_q || dbus_err;
  end
endmodule

// File: rtl/mchk_save.sv
module mchk_save #(
  parameter int             PC_W  = 32,
  parameter int             MSR_W = 32,
  parameter logic [MSR_W-1:0] MASK = '0
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             take,
  input  logic             rfci,
  input  logic [PC_W-1:0]  pc,
  input  logic [MSR_W-1:0] msr_in,
  output logic [PC_W-1:0]  save_pc,
  output logic [MSR_W-1:0] save_msr,
  output logic             msr_ld,
  output logic [MSR_W-1:0] msr_nxt
);
  function automatic logic [MSR_W-1:0] strip_enables(input logic [MSR_W-1:0] s);
    return s & ~MASK;
  endfunction

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      save_pc  <= '0;
      save_msr <= '0;
      msr_ld   <= 1'b0;
      msr_nxt  <= '0;
    end else if (take) begin
      save_pc  <= pc;
      save_msr <= msr_in;
      msr_ld   <= 1'b1;
      msr_nxt  <= strip_enables(msr_in);
    end else if (rfci) begin
      msr_ld   <= 1'b1;
      msr_nxt  <= save_msr;
    end else begin
      msr_ld   <= 1'b0;
    end
  end
endmodule

// File: rtl/mchk_ctrl.sv
module mchk_ctrl import mchk_pkg::*; #(
  parameter int               PC_W   = 32,
  parameter int               MSR_W  = 32,
  parameter int               LINES  = 16,
  parameter int               ME_POS = 12,
  parameter logic [MSR_W-1:0] MASK   = 'h9A00,
  parameter int               VEC_W  = 16,
  parameter logic [VEC_W-1:0] VEC    = 'h0200,
  localparam int              IDX_W  = (LINES > 1) ? $clog2(LINES) : 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             fill_vld,
  input  logic [IDX_W-1:0] fill_idx,
  input  logic             fill_err,
  input  logic             exec_vld,
  input  logic [IDX_W-1:0] exec_idx,
  input  logic [PC_W-1:0]  exec_pc,
  input  logic             dbus_err,
  input  logic [MSR_W-1:0] msr_in,
  input  logic             rfci,
  input  logic             stat_wr,
  input  logic             stat_wd,
  output logic             mc_irq,
  output logic             mc_cause,
  output logic [VEC_W-1:0] mc_vec,
  output logic             inv_vld,
  output logic [IDX_W-1:0] inv_idx,
  output logic [PC_W-1:0]  save_pc,
  output logic [MSR_W-1:0] save_msr,
  output logic             msr_ld,
  output logic [MSR_W-1:0] msr_nxt,
  output logic             imc_sticky
);
  // named internal events, also seen by the checker
  logic      tag_hit, ievt, me, take, dpend_q;
  mc_cause_e take_cause, cause_q;

  assign me   = msr_in[ME_POS];
  assign ievt = exec_vld && tag_hit;

  mchk_tags #(.LINES(LINES), .IDX_W(IDX_W)) u_tags (
    .clk(clk), .rst_n(rst_n),
    .fill_vld(fill_vld), .fill_idx(fill_idx), .fill_err(fill_err),
    .clr_en(ievt), .clr_idx(exec_idx),
    .rd_idx(exec_idx), .rd_hit(tag_hit)
  );

  mchk_arb u_arb (
    .clk(clk), .rst_n(rst_n), .boundary(exec_vld), .me(me), .busy(msr_ld),
    .ievt(ievt), .dbus_err(dbus_err),
    .take(take), .take_cause(take_cause), .dpend_q(dpend_q)
  );

  mchk_save #(.PC_W(PC_W), .MSR_W(MSR_W), .MASK(MASK)) u_save (
    .clk(clk), .rst_n(rst_n), .take(take), .rfci(rfci),
    .pc(exec_pc), .msr_in(msr_in),
    .save_pc(save_pc), .save_msr(save_msr), .msr_ld(msr_ld), .msr_nxt(msr_nxt)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      mc_irq     <= 1'b0;
      cause_q    <= CAUSE_INSTR;
      inv_vld    <= 1'b0;
      inv_idx    <= '0;
      imc_sticky <= 1'b0;
    end else begin
      mc_irq  <= take;
      if (take) cause_q <= take_cause;
      inv_vld <= ievt;
      if (ievt) inv_idx <= exec_idx;
      if (ievt)
        imc_sticky <= 1'b1;
      else if (stat_wr && !stat_wd)
        imc_sticky <= 1'b0;
    end
  end

  assign mc_cause = cause_q;
  assign mc_vec   = VEC;
endmodule

// File: rtl/mchk_props.sv
module mchk_props #(
  parameter int MSR_W  = 32,
  parameter int PC_W   = 32,
  parameter int IDX_W  = 4,
  parameter int ME_POS = 12
) (
  input logic             clk,
  input logic             rst_n,
  input logic             mc_irq,
  input logic             msr_ld,
  input logic [MSR_W-1:0] msr_nxt,
  input logic [MSR_W-1:0] msr_in,
  input logic             take,
  input logic             ievt,
  input logic [IDX_W-1:0] exec_idx,
  input logic [PC_W-1:0]  exec_pc,
  input logic             inv_vld,
  input logic [IDX_W-1:0] inv_idx,
  input logic             imc_sticky,
  input logic             stat_wr,
  input logic             stat_wd,
  input logic [PC_W-1:0]  save_pc
);
  p_one_cycle_r5: assert property (@(posedge clk) disable iff (!rst_n)
    mc_irq |=> !mc_irq);
  p_busy_blocks_r5: assert property (@(posedge clk) disable iff (!rst_n)
    msr_ld |-> !take);
  p_needs_enable_r9: assert property (@(posedge clk) disable iff (!rst_n)
    take |-> msr_in[ME_POS]);
  p_entry_drops_me_r4: assert property (@(posedge clk) disable iff (!rst_n)
    mc_irq |-> (msr_ld && !msr_nxt[ME_POS]));
  p_save_pc_r4: assert property (@(posedge clk) disable iff (!rst_n)
    take |=> save_pc == $past(exec_pc));
  p_inval_r6: assert property (@(posedge clk) disable iff (!rst_n)
    ievt |=> (inv_vld && inv_idx == $past(exec_idx)));
  p_sticky_set_r8: assert property (@(posedge clk) disable iff (!rst_n)
    ievt |=> imc_sticky);
  p_sticky_clr_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (stat_wr && !stat_wd && !ievt) |=> !imc_sticky);
endmodule

bind mchk_ctrl mchk_props #(
  .MSR_W(MSR_W), .PC_W(PC_W), .IDX_W(IDX_W), .ME_POS(ME_POS)
) i_props (.*);

// File: tb/test_mchk_ctrl.sv
module test_mchk_ctrl;
  localparam int L = 8, IW = 3, ME = 12;
  localparam logic [31:0] MASK = 32'h9A00;

  logic clk = 0, rst_n = 0;
  logic fill_vld = 0, fill_err = 0, exec_vld = 0, dbus_err = 0, rfci = 0;
  logic stat_wr = 0, stat_wd = 0;
  logic [IW-1:0] fill_idx = 0, exec_idx = 0;
  logic [31:0] exec_pc = 0, msr_in = 32'h9000;
  logic mc_irq, mc_cause, inv_vld, msr_ld, imc_sticky;
  logic [15:0] mc_vec;
  logic [IW-1:0] inv_idx;
  logic [31:0] save_pc, save_msr, msr_nxt;
  int total = 0, bad = 0;
  bit done = 0;

  always #4 clk = ~clk;   // 125 MHz

  mchk_ctrl #(.LINES(L)) i_mchk_ctrl (.*);

  // ---------------- reference model ----------------
  bit m_tag [L];
  bit m_dp, m_irq, m_cause, m_inv, m_st, m_ld, ie, ok, ti, td;
  logic [IW-1:0] m_invidx;
  logic [31:0] m_spc, m_smsr, m_nxt;

  function automatic logic [31:0] entry_msr(input logic [31:0] s);
    logic [31:0] r = s;
    for (int b = 0; b < 32; b++) if (MASK[b]) r[b] = 1'b0;
    return r;
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      foreach (m_tag[i]) m_tag[i] = 0;
      m_dp = 0; m_irq = 0; m_inv = 0; m_st = 0; m_ld = 0; m_cause = 0;
      m_invidx = 0; m_spc = 0; m_smsr = 0; m_nxt = 0;
    end else begin
      ie = exec_vld && m_tag[exec_idx];
      ok = exec_vld && msr_in[ME] && !m_ld;
      ti = ok && ie;
      td = ok && !ie && m_dp;
      if (ti || td) begin
        m_nxt = entry_msr(msr_in); m_ld = 1; m_spc = exec_pc; m_smsr = msr_in; m_cause = td;
      end else if (rfci) begin
        m_nxt = m_smsr; m_ld = 1;
      end else m_ld = 0;
      m_irq = ti || td;
      if (ti || td || !msr_in[ME]) m_dp = 0; else if (dbus_err) m_dp = 1;
      m_inv = ie; if (ie) m_invidx = exec_idx;
      if (ie) m_st = 1; else if (stat_wr && !stat_wd) m_st = 0;
      if (ie) m_tag[exec_idx] = 0;
      if (fill_vld) m_tag[fill_idx] = fill_err;
    end
  end

  task automatic chk(input bit good, input string req, input logic [63:0] act, input logic [63:0] exp);
    total++;
    if (!good) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic compare_model();
    chk(mc_irq === m_irq, "R5 irq", 64'(mc_irq), 64'(m_irq));
    if (m_irq) begin
      chk(mc_cause === m_cause, "R12 cause", 64'(mc_cause), 64'(m_cause));
      chk(save_pc === m_spc && save_msr === m_smsr, "R4 save pair", {save_pc, save_msr}, {m_spc, m_smsr});
    end
    chk(inv_vld === m_inv, "R6 inv", 64'(inv_vld), 64'(m_inv));
    if (m_inv) chk(inv_idx === m_invidx, "R6 idx", 64'(inv_idx), 64'(m_invidx));
    chk(imc_sticky === m_st, "R8 sticky", 64'(imc_sticky), 64'(m_st));
    chk(msr_ld === m_ld, "R13 ld", 64'(msr_ld), 64'(m_ld));
    if (m_ld) chk(msr_nxt === m_nxt, "R4 nxt", 64'(msr_nxt), 64'(m_nxt));
  endtask

  task automatic tick();
    @(posedge clk);
    @(negedge clk);
    compare_model();
    if (msr_ld) msr_in = msr_nxt;
    fill_vld = 0; exec_vld = 0; dbus_err = 0; rfci = 0; stat_wr = 0;
  endtask

  task automatic do_fill(input int idx, input bit err);
    fill_vld = 1; fill_idx = IW'(idx); fill_err = err; tick();
  endtask

  task automatic do_exec(input int idx, input logic [31:0] pc);
    exec_vld = 1; exec_idx = IW'(idx); exec_pc = pc; tick();
  endtask

  task automatic do_ret();
    rfci = 1; tick(); tick();
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog expired");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd4051));
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    chk(!mc_irq && !msr_ld && !inv_vld && !imc_sticky, "R1 reset",
        {mc_irq, msr_ld, inv_vld, imc_sticky}, 0);
    chk(mc_vec === 16'h0200, "R2 vector", 64'(mc_vec), 64'h200);

    // R3: a faulty fill alone raises nothing; executing from the line does
    do_fill(3, 1);
    chk(!mc_irq && !inv_vld, "R3 no irq at fill", 64'(mc_irq), 0);
    exec_vld = 1; exec_idx = 3; exec_pc = 32'h1000;
    @(posedge clk); @(negedge clk);
    chk(mc_irq && mc_cause == 1'b0, "R3 instr irq", {mc_irq, mc_cause}, 2'b10);
    chk(mc_vec === 16'h0200, "R2 vector at irq", 64'(mc_vec), 64'h200);
    chk(save_pc == 32'h1000 && save_msr == 32'h9000, "R4 saved", {save_pc, save_msr}, {32'h1000, 32'h9000});
    chk(msr_ld && msr_nxt == 32'h0, "R4 enables cleared", 64'(msr_nxt), 0);
    chk(inv_vld && inv_idx == 3, "R6 invalidate line 3", 64'(inv_idx), 3);
    chk(imc_sticky, "R8 sticky set", 64'(imc_sticky), 1);
    compare_model();
    msr_in = 32'h9000;    // force the enable back on while msr_ld is still high
    exec_vld = 0;
    fill_vld = 1; fill_idx = 1; fill_err = 1;
    @(posedge clk); @(negedge clk);
    fill_vld = 0;
    chk(!mc_irq, "R5 one cycle", 64'(mc_irq), 0);
    msr_in = 32'h0;
    // R5: boundary on a tagged line while msr_ld=1 takes nothing
    rfci = 1; tick();
    chk(msr_ld && msr_nxt == 32'h9000, "R13 restore", 64'(msr_nxt), 64'h9000);
    msr_in = 32'h9000;
    exec_vld = 1; exec_idx = 1; exec_pc = 32'h40; @(posedge clk); @(negedge clk);
    exec_vld = 0;
    chk(!mc_irq && inv_vld, "R5 busy blocks take", {mc_irq, inv_vld}, 2'b01);
    compare_model();
    tick();
    chk(save_pc == 32'h1000, "R13 return address", 64'(save_pc), 64'h1000);
    // R6 / R7: tag cleared by invalidation
    do_exec(3, 32'h1004);
    chk(!mc_irq && !inv_vld, "R6 tag cleared", {mc_irq, inv_vld}, 0);
    // R8: write 1 has no effect, write 0 clears
    stat_wr = 1; stat_wd = 1; tick();
    chk(imc_sticky, "R8 write one ignored", 64'(imc_sticky), 1);
    stat_wr = 1; stat_wd = 0; tick();
    chk(!imc_sticky, "R8 write zero clears", 64'(imc_sticky), 0);
    // R9: disabled instruction error still sets sticky and invalidates
    msr_in = 32'h8000;
    do_fill(5, 1);
    do_exec(5, 32'h2000);
    chk(!mc_irq && inv_vld && imc_sticky, "R9 disabled", {mc_irq, inv_vld, imc_sticky}, 3'b011);
    // R11: data error while disabled is dropped
    dbus_err = 1; tick();
    msr_in = 32'h9000;
    do_exec(0, 32'h3000);
    chk(!mc_irq, "R11 not persistent", 64'(mc_irq), 0);
    // R10: data error taken at next boundary
    dbus_err = 1; tick();
    do_exec(0, 32'h3004);
    chk(mc_irq && mc_cause == 1'b1 && save_pc == 32'h3004, "R10 data irq", {mc_cause, save_pc}, {1'b1, 32'h3004});
    do_ret();
    // R10: error at the boundary itself is taken one boundary later
    dbus_err = 1; exec_vld = 1; exec_idx = 0; exec_pc = 32'h3100; tick();
    chk(!mc_irq, "R10 same-cycle not taken", 64'(mc_irq), 0);
    do_exec(0, 32'h3104);
    chk(mc_irq && mc_cause == 1'b1, "R10 later boundary", 64'(mc_cause), 1);
    do_ret();
    // R12: both pending, instruction wins, data dropped
    do_fill(2, 1);
    dbus_err = 1; tick();
    do_exec(2, 32'h4000);
    chk(mc_irq && mc_cause == 1'b0, "R12 instr first", 64'(mc_cause), 0);
    do_ret();
    do_exec(0, 32'h4100);
    chk(!mc_irq, "R12 data dropped", 64'(mc_irq), 0);
    // R7: fill racing invalidation wins; clean refill clears tag
    msr_in = 32'h8000;
    do_fill(4, 1);
    fill_vld = 1; fill_idx = 4; fill_err = 1;
    do_exec(4, 32'h5000);
    do_exec(4, 32'h5004);
    chk(inv_vld && inv_idx == 4, "R7 fill wins race", 64'(inv_idx), 4);
    do_fill(6, 1);
    do_fill(6, 0);
    do_exec(6, 32'h5100);
    chk(!inv_vld, "R7 clean refill clears", 64'(inv_vld), 0);
    msr_in = 32'h9000;

    // constrained random
    for (int n = 0; n < 4000; n++) begin
      fill_vld = ($urandom % 4) == 0;
      fill_idx = IW'($urandom);
      fill_err = $urandom % 2;
      exec_vld = ($urandom % 2) == 0;
      exec_idx = IW'($urandom);
      exec_pc  = $urandom & 32'hFFFF_FFFC;
      dbus_err = ($urandom % 8) == 0;
      stat_wr  = ($urandom % 16) == 0;
      stat_wd  = $urandom % 2;
      rfci     = ($urandom % 24) == 0;
      if (($urandom % 16) == 0) msr_in[ME] = ~msr_in[ME];
      tick();
    end

    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule